// File: doc/BRIEF.md
# Packed Multi-Precision Multiply-Accumulator

This block multiplies two 32-bit operand words and adds the result into a 64-bit packed accumulator. It uses one datapath at three precisions. In full-width mode it forms a single 32x32 product. In half-width mode it forms two independent 16x16 products. In quarter-width mode it forms four independent 8x8 products. Each mode can treat its operands as unsigned or as two's complement.

Each lane's product and running sum stay inside their own field of the accumulator. The datapath is one shared partial-product array with a carry-save reduction. The mode selects which operand bits feed each partial-product row. The mode also cuts every carry path that would cross from one product field into the next, both in the reduction and in the final adder.

The running accumulator is fed back into the reduction as one more row, so accumulation costs no separate adder. Operands enter through a valid/ready port. The only back-pressure is a clear request: while `clr_i` is high, `in_ready_o` is low and an offered beat is not taken. On every other cycle a valid beat is taken. Its result appears on `acc_o` after the next rising clock edge.

Top module: `simd_mac`

## Requirements
- R1: While `rst_n` is low and after it is released, `acc_o` reads 0 until the first accepted beat or clear.
- R2: `mode_i` encoding: 2'b00 gives one lane with operands [31:0] and result field [63:0]. 2'b01 gives two lanes; lane i takes operand bits [16i+15:16i] and owns field [32i+31:32i]. 2'b10 and 2'b11 both give four lanes; lane i takes operand bits [8i+7:8i] and owns field [16i+15:16i].
- R3: With `signed_i`=0, each accepted beat adds the zero-extended lane product to each lane field.
- R4: With `signed_i`=1, lane operands are two's complement. The product is sign-extended only to the top of its own field.
- R5: No carry or sign bit passes between lane fields. A lane whose multiplicand bits are all zero keeps its field unchanged.
- R6: Each lane field wraps modulo 2^(2w), where w is the lane width. Overflow in one lane never alters another lane.
- R7: `clr_i` high zeroes all of `acc_o` at the next edge. In that cycle `in_ready_o` is low and a valid beat is discarded.
- R8: In a cycle with no accepted beat and no clear, `acc_o` holds its value.
- R9: Mode and signedness are sampled with each beat. A change applies to the very next accepted beat, and the result is visible one cycle after acceptance.
- R10: `in_ready_o` is high on every cycle in which `clr_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all lanes |
| in_valid_i | input | 1 | Operand beat offered |
| in_ready_o | output | 1 | Beat can be taken this cycle |
| op_a_i | input | 32 | Packed multiplicand lanes |
| op_b_i | input | 32 | Packed multiplier lanes |
| mode_i | input | 2 | Lane precision select (see R2) |
| signed_i | input | 1 | 1: two's complement operands |
| acc_o | output | 64 | Packed per-lane accumulator |

## Verification
Several properties are checked on every cycle:
- the full-width result against a direct product of the sampled operands,
- unchanged fields for lanes whose multiplicand is zero in the two narrow modes,
- holding when idle,
- clearing,
- readiness.

The bench's per-lane reference model is compared every clock. Only the bench's scenarios can show the following:
- lane wrap-around after repeated large products,
- the sign corners at the most negative values,
- the alias of the fourth mode code,
- a mode switch between back-to-back beats.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_HALF  = 2'b01,
    MODE_QUART = 2'b10,
    MODE_QALT  = 2'b11
  } mac_mode_e;

  // Lane operand width for a given mode and datapath width.
  function automatic int lane_width(input logic [1:0] m, input int dw);
    case (mac_mode_e'(m))
      MODE_FULL: lane_width = dw;
      MODE_HALF: lane_width = dw / 2;
      default:   lane_width = dw / 4;
    endcase
  endfunction
endpackage

// File: rtl/mac_ppgen.sv
module mac_ppgen
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0]             op_a,
  input  logic [DATA_W-1:0]             op_b,
  input  logic [1:0]                    mode,
  input  logic                          sgn,
  output logic [DATA_W-1:0][ACC_W-1:0]  rows,
  output logic [ACC_W-1:0]              corr
);
  always_comb begin
    int w;
    int lane;
    int in_base;
    int fld_base;
    int pos;
    logic [ACC_W-1:0] lmask;
    logic [ACC_W-1:0] fmask;
    logic [ACC_W-1:0] a_ext;
    logic [ACC_W-1:0] r;
    w     = lane_width(mode, DATA_W);
    lmask = (ACC_W'(1) << w) - ACC_W'(1);
    fmask = (2 * w >= ACC_W) ? '1 : ((ACC_W'(1) << (2 * w)) - ACC_W'(1));
    corr  = '0;
    for (int j = 0; j < DATA_W; j++) begin
      lane     = j / w;
      in_base  = lane * w;
      fld_base = 2 * in_base;
      pos      = j - in_base;
      // multiplicand of this row's lane, extended to the lane's field
      a_ext = (ACC_W'(op_a) >> in_base) & lmask;
      if (sgn && a_ext[w-1]) a_ext = a_ext | ~lmask;
      r = (a_ext << pos) & fmask;
      if (!op_b[j]) begin
        r = '0;
      end else if (sgn && (pos == w - 1)) begin
        // top multiplier bit carries negative weight: -x = ~x + 1
        r = ~r & fmask;
        corr[fld_base] = 1'b1;
      end
      rows[j] = r << fld_base;
    end
  end
endmodule

// File: rtl/mac_csa3.sv
module mac_csa3 #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic [W-1:0] kill,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] maj;
  assign s   = x ^ y ^ z;
  assign maj = (x & y) | (x & z) | (y & z);
  assign c   = (maj << 1) & ~kill;
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
  parameter int ROWS = 34,
  parameter int W    = 64,
  localparam int STAGES = ROWS - 2
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  input  logic [W-1:0]           kill,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           car_o
);
  logic [STAGES-1:0][W-1:0] s_st;
  logic [STAGES-1:0][W-1:0] c_st;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      mac_csa3 #(.W(W)) u_csa (
        .x(rows[0]), .y(rows[1]), .z(rows[2]), .kill(kill),
        .s(s_st[k]), .c(c_st[k])
      );
    end else begin : g_next
      mac_csa3 #(.W(W)) u_csa (
        .x(s_st[k-1]), .y(c_st[k-1]), .z(rows[k+2]), .kill(kill),
        .s(s_st[k]), .c(c_st[k])
      );
    end
  end

  assign sum_o = s_st[STAGES-1];
  assign car_o = c_st[STAGES-1];
endmodule

// File: rtl/mac_seg_adder.sv
module mac_seg_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] kill,
  output logic [W-1:0] s
);
  always_comb begin
    logic cy;
    cy = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (kill[k]) cy = 1'b0;
      s[k] = x[k] ^ y[k] ^ cy;
      cy   = (x[k] & y[k]) | (x[k] & cy) | (y[k] & cy);
    end
  end
endmodule

// File: rtl/simd_mac.sv
module simd_mac
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W,
  localparam int NROWS = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        mode_i,
  input  logic              signed_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [DATA_W-1:0][ACC_W-1:0] pp_rows;
  logic [ACC_W-1:0]             pp_corr;
  logic [NROWS-1:0][ACC_W-1:0]  tree_in;
  logic [ACC_W-1:0]             kill;
  logic [ACC_W-1:0]             t_sum;
  logic [ACC_W-1:0]             t_car;
  logic [ACC_W-1:0]             acc_nxt;
  logic [ACC_W-1:0]             acc_q;

  // Lane-boundary carry kills: no carry may enter the first bit of a field.
  always_comb begin
    int fw;
    fw   = 2 * lane_width(mode_i, DATA_W);
    kill = '0;
    for (int k = 1; k < ACC_W; k++) begin
      if ((k % fw) == 0) kill[k] = 1'b1;
    end
  end

  mac_ppgen #(.DATA_W(DATA_W)) u_ppgen (
    .op_a(op_a_i), .op_b(op_b_i), .mode(mode_i), .sgn(signed_i),
    .rows(pp_rows), .corr(pp_corr)
  );

  for (genvar r = 0; r < DATA_W; r++) begin : g_rows
    assign tree_in[r] = pp_rows[r];
  end
  assign tree_in[DATA_W]   = pp_corr;
  assign tree_in[DATA_W+1] = acc_q;   // accumulate inside the reduction

  mac_csa_tree #(.ROWS(NROWS), .W(ACC_W)) u_tree (
    .rows(tree_in), .kill(kill), .sum_o(t_sum), .car_o(t_car)
  );

  mac_seg_adder #(.W(ACC_W)) u_cpa (
    .x(t_sum), .y(t_car), .kill(kill), .s(acc_nxt)
  );

  assign in_ready_o = ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr_i)      acc_q <= '0;
    else if (in_valid_i) acc_q <= acc_nxt;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mac_sva.sv
module mac_sva #(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W,
  localparam int HW = DATA_W / 2,
  localparam int QW = DATA_W / 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [1:0]        mode_i,
  input logic              signed_i,
  input logic [ACC_W-1:0]  acc_o
);
  logic             take;
  logic [ACC_W-1:0] ea;
  logic [ACC_W-1:0] eb;
  logic [ACC_W-1:0] full_exp;

  assign take     = in_valid_i && in_ready_o;
  assign ea       = signed_i ? ACC_W'($signed(op_a_i)) : ACC_W'(op_a_i);
  assign eb       = signed_i ? ACC_W'($signed(op_b_i)) : ACC_W'(op_b_i);
  assign full_exp = acc_o + ea * eb;

  AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_i == 2'b00) |=> acc_o == $past(full_exp)); // R3 R4

  AST_QUART_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_i[1] && op_a_i[QW-1:0] == '0) |=> $stable(acc_o[2*QW-1:0])); // R5

  AST_HALF_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_i == 2'b01 && op_a_i[DATA_W-1:HW] == '0)
      |=> $stable(acc_o[ACC_W-1:DATA_W])); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_o == '0); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid_i && !clr_i) |=> $stable(acc_o)); // R8

  AST_READY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> in_ready_o); // R10
endmodule

bind simd_mac mac_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .mode_i(mode_i), .signed_i(signed_i), .acc_o(acc_o)
);

// File: tb/sim_simd_mac.sv
module sim_simd_mac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i;
  logic        in_valid_i;
  logic        in_ready_o;
  logic [31:0] op_a_i;
  logic [31:0] op_b_i;
  logic [1:0]  mode_i;
  logic        signed_i;
  logic [63:0] acc_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic [63:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_mac u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .mode_i(mode_i), .signed_i(signed_i), .acc_o(acc_o)
  );

  // Behavioural reference: per-lane products added into per-lane fields.
  function automatic logic [63:0] ref_step(logic [63:0] acc, logic [31:0] a,
                                           logic [31:0] b, logic [1:0] m, logic s);
    int w = (m == 2'b00) ? 32 : (m == 2'b01) ? 16 : 8;
    logic [63:0] res = acc;
    for (int l = 0; l < 32 / w; l++) begin
      logic [63:0] lm = (64'd1 << w) - 64'd1;
      logic [63:0] fm = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
      logic [63:0] xa = (64'(a) >> (l * w)) & lm;
      logic [63:0] xb = (64'(b) >> (l * w)) & lm;
      logic [63:0] fld;
      if (s && xa[w-1]) xa = xa | ~lm;
      if (s && xb[w-1]) xb = xb | ~lm;
      fld = ((acc >> (2 * w * l)) & fm) + xa * xb;
      fld = fld & fm;
      res = (res & ~(fm << (2 * w * l))) | (fld << (2 * w * l));
    end
    return res;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; compare acc_o at the next falling edge.
  task automatic step(string tag, logic clr, logic vld, logic [31:0] a,
                      logic [31:0] b, logic [1:0] m, logic s);
    clr_i = clr; in_valid_i = vld; op_a_i = a; op_b_i = b;
    mode_i = m; signed_i = s;
    #1;
    check({tag, " ready"}, {63'd0, in_ready_o}, {63'd0, ~clr});
    if (clr)      model = '0;
    else if (vld) model = ref_step(model, a, b, m, s);
    @(negedge clk);
    check(tag, acc_o, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_i = 0; in_valid_i = 0; op_a_i = '0; op_b_i = '0;
    mode_i = 2'b00; signed_i = 0; model = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", acc_o, 64'd0);
    rst_n = 1'b1;
    step("R1 after reset idle", 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 0);

    // R3 full-width unsigned, extreme operands
    step("R3 full unsigned max", 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 0);
    step("R8 idle hold", 0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 2'b01, 1);
    step("R7 clear with valid", 1, 1, 32'h0000_0005, 32'h0000_0007, 2'b00, 0);
    // R4 full-width signed corners
    step("R4 full signed -1*-1", 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1);
    step("R4 full signed min*min", 0, 1, 32'h8000_0000, 32'h8000_0000, 2'b00, 1);
    step("R4 full signed min*1", 0, 1, 32'h8000_0000, 32'h0000_0001, 2'b00, 1);
    step("R7 clear", 1, 0, 32'h0, 32'h0, 2'b00, 0);

    // R2 half mode placement, R4 signed lanes
    step("R2 half lanes", 0, 1, 32'h0003_0002, 32'h0005_0007, 2'b01, 0);
    step("R4 half signed", 0, 1, 32'h8000_FFFF, 32'h8000_0003, 2'b01, 1);
    step("R5 half lane1 zero", 0, 1, 32'h0000_7FFF, 32'hFFFF_8000, 2'b01, 1);
    // R6 wrap: repeated max products overflow lane 0, lane 1 untouched
    step("R7 clear", 1, 0, 32'h0, 32'h0, 2'b00, 0);
    for (int i = 0; i < 6; i++)
      step("R6 half wrap", 0, 1, 32'h0000_FFFF, 32'h0000_FFFF, 2'b01, 0);
    step("R6 quart wrap", 0, 1, 32'h0000_00FF, 32'h0000_00FF, 2'b10, 0);

    // R2 quarter mode and its alias code, R5 isolation
    step("R7 clear", 1, 0, 32'h0, 32'h0, 2'b00, 0);
    step("R2 quart lanes", 0, 1, 32'h0403_0201, 32'h0807_0605, 2'b10, 0);
    step("R2 quart alias 11", 0, 1, 32'h8080_8080, 32'h7F80_FF01, 2'b11, 1);
    step("R5 quart lane0 zero", 0, 1, 32'hFF80_7F00, 32'hFFFF_FFFF, 2'b10, 1);

    // R9 back-to-back mode/sign switch
    step("R9 switch to full", 0, 1, 32'hFFFF_FFFE, 32'h0000_0003, 2'b00, 1);
    step("R9 switch to quart", 0, 1, 32'hFEFD_FCFB, 32'h0102_0304, 2'b10, 0);
    step("R9 switch to half", 0, 1, 32'hFFFF_0001, 32'hFFFF_0001, 2'b01, 1);
    step("R10 ready idle", 0, 0, 32'h0, 32'h0, 2'b01, 0);

    // mixed random traffic across all modes and signedness
    for (int i = 0; i < 300; i++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      logic s = 1'($urandom_range(0, 1));
      logic c = ($urandom_range(0, 19) == 0);
      logic v = ($urandom_range(0, 4) != 0);
      step("R3 R4 R6 random", c, v, $urandom, $urandom, m, s);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule